// File: doc/BRIEF.md
# Variable-Length Instruction Splitter

This block takes the bytes that sit at the current program counter and splits them into the fields of one instruction. It works on a 64-bit teaching instruction set whose instructions are one to ten bytes long. The input is a ten-byte window in little-endian order: byte 0 is the lowest byte of the `window` bus, and it is the byte at the program counter. The program counter comes in alongside the window. The block has no clock and no state. Everything it reports follows from the leading opcode nibble and the one or two bytes that come after it.

The outputs are:
- the opcode and function nibbles;
- the two register identifiers;
- an optional 8-byte constant, which is an immediate, a displacement or an absolute target;
- the instruction length;
- the address of the sequential successor;
- a flag that marks an illegal encoding.

A fetch stage places the block between instruction memory and the register-read logic. It uses `pcNext` for straight-line flow and `badInstr` to raise an invalid-instruction status.

Opcode values: 0 stop, 1 no-op, 2 register move (conditional or not), 3 immediate to register, 4 register to memory, 5 memory to register, 6 arithmetic/logic, 7 branch, 8 subroutine call, 9 subroutine return, A push, B pop. Register ID 0xF means "no register".

Top module: `insnSplitter`

## Requirements
- R1: `icode` equals bits 7:4 of byte 0 and `ifun` equals bits 3:0 of byte 0, for every window.
- R2: `instLen` is 1 for opcodes 0, 1 and 9. It is 2 for opcodes 2, 6, A and B. It is 9 for opcodes 7 and 8, and 10 for opcodes 3, 4 and 5. An opcode above B reports length 1.
- R3: For opcodes 2, 3, 4, 5, 6, A and B, `regA` is the high nibble of byte 1 and `regB` is its low nibble. For every other opcode both report 0xF, whatever byte 1 holds.
- R4: For opcodes 7 and 8, `valC` is bytes 1..8 read little-endian, with byte 1 least significant. For opcodes 3, 4 and 5, `valC` is bytes 2..9 read the same way. For all other opcodes `valC` is zero, and trailing bytes have no effect.
- R5: `pcNext` equals `pcIn + instLen`, modulo 2^64.
- R6: An opcode above 0xB asserts `badInstr`.
- R7: A function nibble outside the range defined for its opcode asserts `badInstr`. The ranges are 0..6 for opcodes 2 and 7, 0..3 for opcode 6, and only 0 for every other defined opcode.
- R8: Opcode 3 with a register-A nibble other than 0xF asserts `badInstr`. So does opcode A or B with a register-B nibble other than 0xF.
- R9: An all-zero window decodes as a legal one-byte stop instruction with both registers 0xF and a zero constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pcIn | input | 64 | Address of byte 0 of the window |
| window | input | 80 | Ten instruction bytes, byte 0 in bits 7:0 |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| regA | output | 4 | First register ID, 0xF when absent |
| regB | output | 4 | Second register ID, 0xF when absent |
| valC | output | 64 | Constant field, zero when absent |
| instLen | output | 4 | Instruction length in bytes |
| pcNext | output | 64 | Sequential successor address |
| badInstr | output | 1 | Illegal encoding detected |

## Verification
The bench fills the bytes beyond each short instruction with non-zero filler. A splitter that leaked trailing bytes into `valC` or the register fields would then show visible garbage. The branch and load cases tell apart the constant that starts at byte 1 from the one that starts at byte 2. A design that picked the wrong start, or reversed the byte order, would report a shifted target or a byte-swapped displacement such as the sign-extended -12. The legality cases each break one rule in isolation: an opcode past B, a function nibble one beyond its range, a real register where 0xF is required. A decoder missing any one of these rules would leave `badInstr` low. A program counter near the top of the address space checks that the successor address wraps and is not saturated.

// File: rtl/decodePkg.sv
package decodePkg;
  localparam int WORD_BYTES = 8;
  localparam int WIN_BYTES  = WORD_BYTES + 2;
  localparam int LEN_W      = $clog2(WIN_BYTES + 1);
  localparam logic [3:0] REG_NONE = 4'hF;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVE  = 4'h2;
  localparam logic [3:0] OP_IMM   = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  typedef struct packed {
    logic             useRegs;
    logic             constAt1;
    logic             constAt2;
    logic [LEN_W-1:0] len;
  } ctlStrobes_t;
endpackage

// File: rtl/splitCtl.sv
module splitCtl
  import decodePkg::*;
(
  input  logic [7:0]  opByte,
  input  logic [7:0]  regByte,
  output ctlStrobes_t strb,
  output logic        bad
);
  logic [3:0] op, fn, rHi, rLo, fnMax;
  logic       opOk, regOk;

  assign op  = opByte[7:4];
  assign fn  = opByte[3:0];
  assign rHi = regByte[7:4];
  assign rLo = regByte[3:0];

  always_comb begin
    strb.useRegs  = 1'b0;
    strb.constAt1 = 1'b0;
    strb.constAt2 = 1'b0;
    strb.len      = LEN_W'(1);
    opOk  = 1'b1;
    regOk = 1'b1;
    fnMax = 4'd0;
    case (op)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_MOVE: begin
        strb.useRegs = 1'b1;
        strb.len     = LEN_W'(2);
        fnMax        = 4'd6;
      end
      OP_ALU: begin
        strb.useRegs = 1'b1;
        strb.len     = LEN_W'(2);
        fnMax        = 4'd3;
      end
      OP_IMM: begin
        strb.useRegs  = 1'b1;
        strb.constAt2 = 1'b1;
        strb.len      = LEN_W'(WIN_BYTES);
        regOk         = (rHi == REG_NONE);
      end
      OP_STORE, OP_LOAD: begin
        strb.useRegs  = 1'b1;
        strb.constAt2 = 1'b1;
        strb.len      = LEN_W'(WIN_BYTES);
      end
      OP_JUMP: begin
        strb.constAt1 = 1'b1;
        strb.len      = LEN_W'(WORD_BYTES + 1);
        fnMax         = 4'd6;
      end
      OP_CALL: begin
        strb.constAt1 = 1'b1;
        strb.len      = LEN_W'(WORD_BYTES + 1);
      end
      OP_PUSH, OP_POP: begin
        strb.useRegs = 1'b1;
        strb.len     = LEN_W'(2);
        regOk        = (rLo == REG_NONE);
      end
      default: opOk = 1'b0;
    endcase
    bad = !opOk || (fn > fnMax) || !regOk;
  end
endmodule

// File: rtl/splitData.sv
module splitData
  import decodePkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic [PC_W-1:0]        pcIn,
  input  logic [8*WIN_BYTES-1:0] window,
  input  ctlStrobes_t            strb,
  output logic [3:0]             icode,
  output logic [3:0]             ifun,
  output logic [3:0]             regA,
  output logic [3:0]             regB,
  output logic [8*WORD_BYTES-1:0] valC,
  output logic [LEN_W-1:0]       instLen,
  output logic [PC_W-1:0]        pcNext
);
  assign icode = window[7:4];
  assign ifun  = window[3:0];
  assign regA  = strb.useRegs ? window[15:12] : REG_NONE;
  assign regB  = strb.useRegs ? window[11:8]  : REG_NONE;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_constByte
    always_comb begin
      if (strb.constAt1)      valC[8*k +: 8] = window[8*(k+1) +: 8];
      else if (strb.constAt2) valC[8*k +: 8] = window[8*(k+2) +: 8];
      else                    valC[8*k +: 8] = 8'h00;
    end
  end

  assign instLen = strb.len;
  assign pcNext  = pcIn + PC_W'(strb.len);
endmodule

// File: rtl/insnSplitter.sv
module insnSplitter
  import decodePkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic [PC_W-1:0]         pcIn,
  input  logic [8*WIN_BYTES-1:0]  window,
  output logic [3:0]              icode,
  output logic [3:0]              ifun,
  output logic [3:0]              regA,
  output logic [3:0]              regB,
  output logic [8*WORD_BYTES-1:0] valC,
  output logic [LEN_W-1:0]        instLen,
  output logic [PC_W-1:0]         pcNext,
  output logic                    badInstr
);
  ctlStrobes_t strb;

  splitCtl i_ctl (
    .opByte (window[7:0]),
    .regByte(window[15:8]),
    .strb   (strb),
    .bad    (badInstr)
  );

  splitData #(.PC_W(PC_W)) i_data (
    .pcIn   (pcIn),
    .window (window),
    .strb   (strb),
    .icode  (icode),
    .ifun   (ifun),
    .regA   (regA),
    .regB   (regB),
    .valC   (valC),
    .instLen(instLen),
    .pcNext (pcNext)
  );
endmodule

// File: rtl/insnSplitterChk.sv
module insnSplitterChk
  import decodePkg::*;
#(
  parameter int PC_W = 64
) (
  input logic [PC_W-1:0]         pcIn,
  input logic [8*WIN_BYTES-1:0]  window,
  input logic [3:0]              icode,
  input logic [3:0]              regA,
  input logic [3:0]              regB,
  input logic [8*WORD_BYTES-1:0] valC,
  input logic [LEN_W-1:0]        instLen,
  input logic [PC_W-1:0]         pcNext,
  input logic                    badInstr
);
  logic known;
  assign known = !$isunknown({pcIn, window});

  always_comb begin
    if (known) begin
      // R5: successor address tracks the reported length
      a_r5_next_pc: assert (pcNext == pcIn + PC_W'(instLen));
      // R2: only four lengths exist
      a_r2_len_set: assert (instLen == LEN_W'(1) || instLen == LEN_W'(2) ||
                            instLen == LEN_W'(WORD_BYTES + 1) || instLen == LEN_W'(WIN_BYTES));
      // R6: opcodes past B are never legal
      a_r6_bad_op: assert (!(icode > OP_POP) || badInstr);
      // R3: one-byte instructions expose no registers
      a_r3_no_regs: assert (instLen != LEN_W'(1) || (regA == REG_NONE && regB == REG_NONE));
      // R4: short instructions carry no constant
      a_r4_no_const: assert (instLen > LEN_W'(2) || valC == '0);
      // R9: zero memory decodes as a legal stop
      a_r9_zero_halt: assert (window != '0 || (!badInstr && instLen == LEN_W'(1)));
    end
  end
endmodule

bind insnSplitter insnSplitterChk #(.PC_W(PC_W)) i_chk (
  .pcIn    (pcIn),
  .window  (window),
  .icode   (icode),
  .regA    (regA),
  .regB    (regB),
  .valC    (valC),
  .instLen (instLen),
  .pcNext  (pcNext),
  .badInstr(badInstr)
);

// File: tb/test_insnSplitter.sv
`timescale 1ns/1ps
module test_insnSplitter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] pcIn;
  logic [79:0] window;
  logic [3:0]  icode, ifun, regA, regB, instLen;
  logic [63:0] valC, pcNext;
  logic        badInstr;
  int nChecks = 0;
  int nFails  = 0;

  insnSplitter i_insnSplitter (
    .pcIn(pcIn), .window(window), .icode(icode), .ifun(ifun),
    .regA(regA), .regB(regB), .valC(valC), .instLen(instLen),
    .pcNext(pcNext), .badInstr(badInstr)
  );

  // bytes given in memory order, first byte in the top bits of the literal
  function automatic logic [79:0] memOrder(input logic [79:0] b);
    logic [79:0] r;
    for (int k = 0; k < 10; k++) r[8*k +: 8] = b[8*(9-k) +: 8];
    return r;
  endfunction

  task automatic applyCheck(input string tag, input logic [63:0] pc, input logic [79:0] bytes,
                            input logic [3:0] eIc, input logic [3:0] eFn,
                            input logic [3:0] eRa, input logic [3:0] eRb,
                            input logic [63:0] eC, input logic [3:0] eLen,
                            input logic eBad);
    logic [63:0] eNext;
    @(negedge clk);
    pcIn   = pc;
    window = memOrder(bytes);
    #2;
    eNext = pc + 64'(eLen);
    nChecks++;
    if ({icode, ifun, regA, regB, valC, instLen, pcNext, badInstr} !==
        {eIc, eFn, eRa, eRb, eC, eLen, eNext, eBad}) begin
      nFails++;
      $display("FAIL %s: got ic=%h fn=%h rA=%h rB=%h C=%h len=%0d next=%h bad=%b, expected ic=%h fn=%h rA=%h rB=%h C=%h len=%0d next=%h bad=%b",
               tag, icode, ifun, regA, regB, valC, instLen, pcNext, badInstr,
               eIc, eFn, eRa, eRb, eC, eLen, eNext, eBad);
    end
  endtask

  task automatic testZero;      // R9 R1
    applyCheck("R9 zero window", 64'h0, 80'h0, 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 1'b0);
  endtask

  task automatic testShortForms; // R3 R4 R5
    applyCheck("R3 alu xor", 64'h30, 80'h6300_AAAA_AAAA_AAAA_AAAA,
               4'h6, 4'h3, 4'h0, 4'h0, 64'h0, 4'd2, 1'b0);
    applyCheck("R3 ret ignores byte1", 64'h200, 80'h9012_3456_789A_BCDE_F011,
               4'h9, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 1'b0);
    applyCheck("R3 push", 64'h40, 80'hA03F_5555_5555_5555_5555,
               4'hA, 4'h0, 4'h3, 4'hF, 64'h0, 4'd2, 1'b0);
    applyCheck("R3 pop", 64'h42, 80'hB04F_5555_5555_5555_5555,
               4'hB, 4'h0, 4'h4, 4'hF, 64'h0, 4'd2, 1'b0);
  endtask

  task automatic testConstForms; // R4 R2
    applyCheck("R4 imm", 64'h100, 80'h30F2_CDAB_0000_0000_0000,
               4'h3, 4'h0, 4'hF, 4'h2, 64'hABCD, 4'd10, 1'b0);
    applyCheck("R4 load disp -12", 64'h120, 80'h5015_F4FF_FFFF_FFFF_FFFF,
               4'h5, 4'h0, 4'h1, 4'h5, 64'hFFFF_FFFF_FFFF_FFF4, 4'd10, 1'b0);
    applyCheck("R4 branch eq", 64'h7E, 80'h73A0_0000_0000_0000_0055,
               4'h7, 4'h3, 4'hF, 4'hF, 64'hA0, 4'd9, 1'b0);
    applyCheck("R4 call order", 64'h10, 80'h8088_7766_5544_3322_1199,
               4'h8, 4'h0, 4'hF, 4'hF, 64'h1122_3344_5566_7788, 4'd9, 1'b0);
    applyCheck("R7 branch fn6 legal", 64'h10, 80'h7601_0000_0000_0000_0000,
               4'h7, 4'h6, 4'hF, 4'hF, 64'h1, 4'd9, 1'b0);
  endtask

  task automatic testIllegal;   // R6 R7 R8
    applyCheck("R6 opcode C", 64'h0, 80'hC012_3333_3333_3333_3333,
               4'hC, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 1'b1);
    applyCheck("R7 move fn7", 64'h0, 80'h2712_0000_0000_0000_0000,
               4'h2, 4'h7, 4'h1, 4'h2, 64'h0, 4'd2, 1'b1);
    applyCheck("R7 alu fn4", 64'h0, 80'h6412_0000_0000_0000_0000,
               4'h6, 4'h4, 4'h1, 4'h2, 64'h0, 4'd2, 1'b1);
    applyCheck("R7 nop fn1", 64'h0, 80'h1100_0000_0000_0000_0000,
               4'h1, 4'h1, 4'hF, 4'hF, 64'h0, 4'd1, 1'b1);
    applyCheck("R8 imm regA", 64'h0, 80'h3012_0100_0000_0000_0000,
               4'h3, 4'h0, 4'h1, 4'h2, 64'h1, 4'd10, 1'b1);
    applyCheck("R8 push regB", 64'h0, 80'hA033_0000_0000_0000_0000,
               4'hA, 4'h0, 4'h3, 4'h3, 64'h0, 4'd2, 1'b1);
  endtask

  task automatic testWrap;      // R5
    applyCheck("R5 pc wrap", 64'hFFFF_FFFF_FFFF_FFFE, 80'h30F0_0700_0000_0000_0000,
               4'h3, 4'h0, 4'hF, 4'h0, 64'h7, 4'd10, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    pcIn = '0;
    window = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testZero();
    testShortForms();
    testConstForms();
    testIllegal();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule